// File: doc/BRIEF.md
# Two-Register Serial Host Port with Interrupt Aggregation

This block lets an external host reach two 8-bit host registers over a four-wire serial link on which it is the slave. Every exchange is exactly sixteen clocks long. The first byte is a command: its top bit chooses read or write, the next bit chooses register 0 or register 1, and the six low bits must be zero. The second byte carries the write data, or returns the read data on the serial output. The serial pins are sampled by the block's system clock through synchronizers, so the whole block lives in one clock domain.

Register 0 is a read/write control register. Its low four bits enable the interrupt sources. Register 1 reports the four interrupt sources:
- receive FIFO almost full
- transmit FIFO almost empty
- receive FIFO not empty
- a latched external condition

A single interrupt output is high while any enabled source is pending, and the host reads register 1 to see which source raised it. The serial output has a separate enable for the pad driver. The enable is high only while the data byte of a valid read is being shifted out.

Top module: `spi_hir_slave`

## Requirements
- R1: The select input is active low. Serial input bits are sampled on rising serial-clock edges, most significant bit first. In the command byte, bit 7 = 1 means read and bit 7 = 0 means write. Bit 6 = 1 addresses register 1 and bit 6 = 0 addresses register 0.
- R2: A valid write to register 0 stores the data byte after its eighth bit has arrived. A valid read returns the addressed register's value on the serial output, MSB first, with each bit changed after a falling serial-clock edge. The value is captured when the command byte completes.
- R3: A command byte whose bits 5:0 are not all zero leaves both registers unchanged, and the serial output stays undriven for the whole frame.
- R4: The output enable is low while select is high, during the command byte, and throughout a write. It is high during every bit of the data byte of a valid read.
- R5: If select rises before the sixteenth bit, the frame is dropped with no register change. Each falling edge of select restarts the bit count at zero.
- R6: A read of register 1 returns {0000, external latch, receive not empty, transmit almost empty, receive almost full} in bits 7:0. In a write to register 1, only bit 3 has an effect: a 1 there clears the external latch.
- R7: The external condition sets a sticky latch. The latch stays set until it is cleared through register 1. When a set and a clear fall in the same cycle, the set wins.
- R8: The interrupt output is high one system clock after any source bit in register 1 is 1 while the register 0 bit in the same position is also 1. Otherwise it is low.
- R9: After reset, register 0 and the external latch are zero, and both the output enable and the interrupt output are low.
- R10: Serial clocks beyond the sixteenth bit of a frame are ignored until select is deasserted and asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Serial select from the host, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| misoData | output | 1 | Serial data to the host |
| misoOe | output | 1 | Output enable for the serial data pad driver |
| rxAlmostFull | input | 1 | Receive FIFO almost-full flag |
| txAlmostEmpty | input | 1 | Transmit FIFO almost-empty flag |
| rxNotEmpty | input | 1 | Receive FIFO not-empty flag |
| extCond | input | 1 | External status condition, latched on any high cycle |
| irq | output | 1 | Combined interrupt request |

## Verification
Register 0 is written and read back with several data patterns:
- 0xA5 and 0x5A, whose alternating bits expose a lost or doubled shift or a reversed bit order;
- 0xFF and 0x00, which show a stuck serial line;
- 0x3C, which shows a misplaced byte boundary.

Command bytes with reserved bits set, frames cut off after twelve bits, and frames running to twenty-four bits tell a correct frame decoder apart from one that only counts clocks. Register 1 is read under mixed source levels and under single-cycle pulses of the external condition, which separates the live flags from the sticky latch. The interrupt is tried with matching and non-matching enable masks, which shows that the enables gate the sources position by position.

// File: rtl/spi_hir_pkg.sv
package spi_hir_pkg;

  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int SRC_N      = 4;

  // Strobes from the frame control to the datapath.
  typedef struct packed {
    logic loadTx;     // capture register value into the output shifter
    logic rdSel;      // register chosen for the capture (1 = register 1)
    logic shiftTx;    // advance the output shifter
    logic driveMiso;  // enable the serial output driver
    logic wrReg0;     // commit the received data byte to register 0
    logic wrReg1;     // apply the received data byte to register 1
  } hirStrobeT;

  // Pin events and frame position from the datapath to the control.
  typedef struct packed {
    logic             selActive;
    logic             selStart;
    logic             sckFall;
    logic             ctrlDone;
    logic             dataDone;
    logic [CNT_W-1:0] bitCnt;
    logic [BYTE_W-1:0] rxByte;
  } hirEventT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_HOLD
  } hirStateT;

endpackage

// File: rtl/spi_hir_datapath.sv
module spi_hir_datapath
  import spi_hir_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             mosi,
  input  logic [SRC_N-1:0] srcLevel,  // 0 rx almost full, 1 tx almost empty, 2 rx not empty, 3 external
  input  hirStrobeT        strobe,
  output hirEventT         ev,
  output logic             misoData,
  output logic             misoOe,
  output logic             irq
);

  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_RST = 3'b001;  // select idles high
  localparam int EXT_IDX = SRC_N - 1;

  logic [PIN_N-1:0] pinRaw;
  logic [PIN_N-1:0] pinSync;

  assign pinRaw = {mosi, sclk, csN};

  for (genvar p = 0; p < PIN_N; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{PIN_RST[p]}};
      else       chain <= {chain[SYNC_STAGES-2:0], pinRaw[p]};
    end
    assign pinSync[p] = chain[SYNC_STAGES-1];
  end

  logic selS, sckS, mosiS;
  assign selS  = pinSync[0];
  assign sckS  = pinSync[1];
  assign mosiS = pinSync[2];

  logic sckPrev, selPrev;
  logic sckRise, sckFall, selStart, selActive, frameOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      selPrev <= 1'b1;
    end else begin
      sckPrev <= sckS;
      selPrev <= selS;
    end
  end

  assign sckRise   = sckS & ~sckPrev;
  assign sckFall   = ~sckS & sckPrev;
  assign selStart  = ~selS & selPrev;
  assign selActive = ~selS;

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic              ctrlDoneQ, dataDoneQ;

  assign frameOpen = selActive && (bitCnt != CNT_W'(FRAME_BITS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      rxShift   <= '0;
      ctrlDoneQ <= 1'b0;
      dataDoneQ <= 1'b0;
    end else begin
      ctrlDoneQ <= sckRise && frameOpen && (bitCnt == CNT_W'(BYTE_W - 1));
      dataDoneQ <= sckRise && frameOpen && (bitCnt == CNT_W'(FRAME_BITS - 1));
      if (selStart) begin
        bitCnt <= '0;
      end else if (sckRise && frameOpen) begin
        bitCnt  <= bitCnt + CNT_W'(1);
        rxShift <= {rxShift[BYTE_W-2:0], mosiS};
      end
    end
  end

  // Host registers and interrupt sources.
  logic [BYTE_W-1:0] reg0Q;
  logic              extLatched;
  logic [SRC_N-1:0]  pending;
  logic [BYTE_W-1:0] reg1View;

  assign pending  = {extLatched, srcLevel[EXT_IDX-1:0]};
  assign reg1View = {{(BYTE_W - SRC_N){1'b0}}, pending};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reg0Q      <= '0;
      extLatched <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (strobe.wrReg0) reg0Q <= rxShift;
      if (srcLevel[EXT_IDX])                        extLatched <= 1'b1;
      else if (strobe.wrReg1 && rxShift[EXT_IDX])   extLatched <= 1'b0;
      irq <= |(reg0Q[SRC_N-1:0] & pending);
    end
  end

  // Output shifter.
  logic [BYTE_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.loadTx) begin
      txShift <= strobe.rdSel ? reg1View : reg0Q;
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign misoData = txShift[BYTE_W-1];
  assign misoOe   = strobe.driveMiso;

  assign ev.selActive = selActive;
  assign ev.selStart  = selStart;
  assign ev.sckFall   = sckFall;
  assign ev.ctrlDone  = ctrlDoneQ;
  assign ev.dataDone  = dataDoneQ;
  assign ev.bitCnt    = bitCnt;
  assign ev.rxByte    = rxShift;

  // R2: register 0 changes only under a write strobe from the control
  p_reg0_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(reg0Q) |-> $past(strobe.wrReg0));

  // R7: the external latch holds unless register 1 is written
  p_ext_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (extLatched && !strobe.wrReg1) |=> extLatched);

  // R8: with every enable clear, no interrupt follows
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reg0Q[SRC_N-1:0] == '0) |=> !irq);

  // R4: the driver is enabled only once the command byte is complete
  p_drive_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> (bitCnt >= CNT_W'(BYTE_W)));

  // R1: a frame never captures and commits in the same cycle
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadTx, strobe.wrReg0, strobe.wrReg1}));

endmodule

// File: rtl/spi_hir_control.sv
module spi_hir_control
  import spi_hir_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  hirEventT  ev,
  output hirStrobeT strobe
);

  hirStateT state;
  logic     cmdRead, cmdSel, cmdOk;
  logic     dirBit, selBit, rsvdZero, readOk;

  assign dirBit   = ev.rxByte[BYTE_W-1];
  assign selBit   = ev.rxByte[BYTE_W-2];
  assign rsvdZero = (ev.rxByte[BYTE_W-3:0] == '0);
  assign readOk   = cmdRead && cmdOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cmdRead <= 1'b0;
      cmdSel  <= 1'b0;
      cmdOk   <= 1'b0;
    end else if (!ev.selActive) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (ev.selStart) state <= ST_CMD;
        ST_CMD: if (ev.ctrlDone) begin
          cmdRead <= dirBit;
          cmdSel  <= selBit;
          cmdOk   <= rsvdZero;
          state   <= ST_DATA;
        end
        ST_DATA: if (ev.dataDone) state <= ST_HOLD;
        ST_HOLD: state <= ST_HOLD;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.rdSel     = selBit;
    strobe.loadTx    = (state == ST_CMD) && ev.ctrlDone && dirBit && rsvdZero;
    strobe.shiftTx   = (state == ST_DATA) && readOk && ev.sckFall &&
                       (ev.bitCnt > CNT_W'(BYTE_W));
    strobe.driveMiso = (state == ST_DATA) && readOk && ev.selActive;
    strobe.wrReg0    = (state == ST_DATA) && ev.dataDone && ev.selActive &&
                       !cmdRead && cmdOk && !cmdSel;
    strobe.wrReg1    = (state == ST_DATA) && ev.dataDone && ev.selActive &&
                       !cmdRead && cmdOk && cmdSel;
  end

  // R5: a released select always returns the frame control to idle
  p_abort_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ev.selActive |=> (state == ST_IDLE));

  // R10: a finished frame stays finished while select is held
  p_hold_stays_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && ev.selActive) |=> (state == ST_HOLD));

endmodule

// File: rtl/spi_hir_slave.sv
module spi_hir_slave
  import spi_hir_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  output logic misoData,
  output logic misoOe,
  input  logic rxAlmostFull,
  input  logic txAlmostEmpty,
  input  logic rxNotEmpty,
  input  logic extCond,
  output logic irq
);

  hirStrobeT strobe;
  hirEventT  ev;

  spi_hir_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sclk     (sclk),
    .mosi     (mosi),
    .srcLevel ({extCond, rxNotEmpty, txAlmostEmpty, rxAlmostFull}),
    .strobe   (strobe),
    .ev       (ev),
    .misoData (misoData),
    .misoOe   (misoOe),
    .irq      (irq)
  );

  spi_hir_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .ev     (ev),
    .strobe (strobe)
  );

endmodule

// File: tb/tb_spi_hir_slave.sv
module tb_spi_hir_slave;

  localparam int H = 8;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic rxAlmostFull = 1'b0, txAlmostEmpty = 1'b0, rxNotEmpty = 1'b0, extCond = 1'b0;
  logic misoData, misoOe, irq;

  always #5 clk = ~clk;

  spi_hir_slave dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .misoData(misoData), .misoOe(misoOe),
    .rxAlmostFull(rxAlmostFull), .txAlmostEmpty(txAlmostEmpty),
    .rxNotEmpty(rxNotEmpty), .extCond(extCond), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] rdByte;
  logic oeCtl, oeDatAll, oeDatAny, oeExtra;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends the top nbits of a 24-bit stream, MSB first, and records the output.
  task automatic xfer(input logic [23:0] stream, input int nbits);
    rdByte = '0; oeCtl = 1'b0; oeDatAll = 1'b1; oeDatAny = 1'b0; oeExtra = 1'b0;
    @(negedge clk) csN = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = stream[23-i];
      repeat (H) @(negedge clk);
      if (i < 8) oeCtl = oeCtl | misoOe;
      else if (i < 16) begin
        rdByte   = {rdByte[6:0], misoData};
        oeDatAll = oeDatAll & misoOe;
        oeDatAny = oeDatAny | misoOe;
      end else oeExtra = oeExtra | misoOe;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    csN = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d);
    xfer({c, d, 8'h00}, 16);
  endtask

  task automatic rd(input logic [7:0] c);
    xfer({c, 8'h00, 8'h00}, 16);
  endtask

  // {command, data, expected read}
  localparam logic [23:0] VEC [10] = '{
    {8'h00, 8'hA5, 8'h00}, {8'h80, 8'h00, 8'hA5},
    {8'h00, 8'h5A, 8'h00}, {8'h80, 8'h00, 8'h5A},
    {8'h00, 8'hFF, 8'h00}, {8'h80, 8'h00, 8'hFF},
    {8'h00, 8'h00, 8'h00}, {8'h80, 8'h00, 8'h00},
    {8'h00, 8'h3C, 8'h00}, {8'h80, 8'h00, 8'h3C}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(misoOe == 1'b0, "R9 oe at reset", misoOe, 0);
    chk(irq == 1'b0, "R9 irq at reset", irq, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h80);
    chk(rdByte == 8'h00, "R9 register 0 after reset", rdByte, 0);
    rd(8'hC0);
    chk(rdByte == 8'h00, "R9 register 1 after reset", rdByte, 0);

    // R1 R2 R4: vector walk
    for (int v = 0; v < 10; v++) begin
      xfer(VEC[v], 16);
      chk(oeCtl == 1'b0, "R4 oe during command byte", oeCtl, 0);
      if (VEC[v][23]) begin
        chk(rdByte == VEC[v][7:0], "R2 read data", rdByte, VEC[v][7:0]);
        chk(oeDatAll == 1'b1, "R4 oe through read data byte", oeDatAll, 1);
      end else begin
        chk(oeDatAny == 1'b0, "R4 oe during write", oeDatAny, 0);
      end
      chk(misoOe == 1'b0, "R4 oe with select high", misoOe, 0);
    end

    // R3: reserved bits set
    wr(8'h01, 8'h77);
    chk(oeDatAny == 1'b0, "R3 oe on reserved write", oeDatAny, 0);
    wr(8'h20, 8'h11);
    rd(8'h80);
    chk(rdByte == 8'h3C, "R3 register 0 unchanged", rdByte, 8'h3C);
    rd(8'h81);
    chk(oeDatAny == 1'b0, "R3 oe on reserved read", oeDatAny, 0);

    // R5: cut-off frame, then a full frame restarts the count
    xfer({8'h00, 8'hEE, 8'h00}, 12);
    rd(8'h80);
    chk(rdByte == 8'h3C, "R5 aborted write ignored", rdByte, 8'h3C);
    xfer({8'h80, 8'h00, 8'h00}, 5);
    wr(8'h00, 8'h21);
    rd(8'h80);
    chk(rdByte == 8'h21, "R5 count restarts on select", rdByte, 8'h21);

    // R10: extra clocks after sixteen bits
    xfer({8'h00, 8'h42, 8'h80}, 24);
    chk(oeExtra == 1'b0, "R10 oe during extra clocks", oeExtra, 0);
    rd(8'h80);
    chk(rdByte == 8'h42, "R10 extra bits ignored", rdByte, 8'h42);

    // R6: register 1 view and write effect
    @(negedge clk) begin rxAlmostFull = 1'b1; rxNotEmpty = 1'b1; end
    rd(8'hC0);
    chk(rdByte == 8'h05, "R6 register 1 view", rdByte, 8'h05);
    wr(8'h40, 8'hFF);
    rd(8'hC0);
    chk(rdByte == 8'h05, "R6 write has no effect on flags", rdByte, 8'h05);
    @(negedge clk) begin rxAlmostFull = 1'b0; rxNotEmpty = 1'b0; txAlmostEmpty = 1'b1; end
    rd(8'hC0);
    chk(rdByte == 8'h02, "R6 transmit flag position", rdByte, 8'h02);
    @(negedge clk) txAlmostEmpty = 1'b0;

    // R7: sticky external latch
    @(negedge clk) extCond = 1'b1;
    @(negedge clk) extCond = 1'b0;
    rd(8'hC0);
    chk(rdByte == 8'h08, "R7 external latched", rdByte, 8'h08);
    rd(8'hC0);
    chk(rdByte == 8'h08, "R7 latch survives read", rdByte, 8'h08);
    wr(8'h40, 8'h07);
    rd(8'hC0);
    chk(rdByte == 8'h08, "R7 clear needs bit 3", rdByte, 8'h08);

    // R8: interrupt from the latched source
    wr(8'h00, 8'h08);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R8 irq from external", irq, 1);
    wr(8'h40, 8'h08);
    rd(8'hC0);
    chk(rdByte == 8'h00, "R7 latch cleared", rdByte, 0);
    chk(irq == 1'b0, "R8 irq drops after clear", irq, 0);

    // R8: enables gate sources by position
    wr(8'h00, 8'h00);
    @(negedge clk) rxAlmostFull = 1'b1;
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R8 masked source", irq, 0);
    wr(8'h00, 8'h01);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R8 enabled source", irq, 1);
    wr(8'h00, 8'hFE);
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R8 other enables only", irq, 0);
    @(negedge clk) txAlmostEmpty = 1'b1;
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R8 second source enabled", irq, 1);
    @(negedge clk) begin txAlmostEmpty = 1'b0; rxAlmostFull = 1'b0; end
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R8 no source pending", irq, 0);
    @(negedge clk) rxNotEmpty = 1'b1;
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R8 receive not empty source", irq, 1);
    @(negedge clk) rxNotEmpty = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule